// File: doc/BRIEF.md
# Phase-Seeded Fractional-N Sigma-Delta Modulator

This block generates the per-cycle divide value for a fractional-N frequency synthesizer. It advances once per phase-detector reference cycle. Each cycle it emits an integer divide value equal to a stored integer part plus a small signed correction. The correction comes from a third-order cascade of three first-order accumulators with error cancellation. The average divide ratio over time equals INT + FRAC/MOD. The modulus MOD is an arbitrary programmable value and need not be a power of two.

A one-cycle channel update strobe latches new INT, FRAC and MOD values. The same strobe loads the first accumulator with a PHASE seed and clears the second and third accumulators and the carry delay taps. The error sequence after each update therefore depends only on FRAC, MOD and PHASE. One seed step moves the output phase by one MOD-th of a full turn. A caller can pick the seed that minimises the error current at a chosen cycle after a channel change.

The caller must supply MOD ≥ 1, FRAC < MOD, PHASE < MOD and INT ≥ 3 on each update.

Top module: `phase_seeded_mash`

## Requirements
- R1: While rst_ni is low, and until the first update strobe afterwards, div_o is 0.
- R2: In the cycle after a clock edge with load_i high, div_o equals the int_i value presented at that edge. The int_i, frac_i and mod_i values are stored at that same edge.
- R3: Each of the three accumulators stays below the stored MOD. On each step it adds its input. When the sum is MOD or more, it subtracts MOD once and raises its carry bit. Stage 1 adds FRAC. Stages 2 and 3 add the new value of the stage before them.
- R4: On each edge without an update, div_o becomes INT + c1 + (c2 − c2') + (c3 − 2·c3' + c3''). Here a prime marks the carry of one step earlier and a double prime marks two steps earlier. So div_o always lies between INT − 3 and INT + 4.
- R5: An update loads stage 1 with phase_i and zeroes stages 2 and 3 and all carry delay taps. Two updates with equal INT, FRAC, MOD and PHASE give identical output sequences.
- R6: After an update with FRAC = 0 and PHASE = 0, div_o equals INT on every cycle.
- R7: Over the first MOD·k steps after an update, the sum of (div_o − INT) lies in the range FRAC·k − 1 to FRAC·k + 2.
- R8: While load_i is low, changes on int_i, frac_i, mod_i and phase_i have no effect on div_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference-rate clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Channel update strobe |
| int_i | input | INT_W | Integer part of the divide ratio |
| frac_i | input | MOD_W | Fractional numerator |
| mod_i | input | MOD_W | Fractional modulus |
| phase_i | input | MOD_W | Seed for the first accumulator |
| div_o | output | INT_W+1 | Divide value for the current reference cycle |

## Verification
A wrong accumulator value or a missed wrap first shows as a wrong carry. The output then departs from the arithmetic reference on the very next cycle. A wrong seed or a delay tap left uncleared after an update shows within the first three steps of the new channel. A fault in the cancellation weights can leave single cycles plausible, but it breaks the running-sum bound of R7 at the next multiple of MOD. Sweeping every FRAC and PHASE for several small moduli drives each wrap path and each tap combination.

// File: rtl/mash_pkg.sv
package mash_pkg;
  localparam int STAGES = 3;
  typedef logic signed [3:0] corr_t;
endpackage

// File: rtl/mash_chan_regs.sv
module mash_chan_regs #(
  parameter int INT_W = 8,
  parameter int MOD_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [INT_W-1:0] int_i,
  input  logic [MOD_W-1:0] frac_i,
  input  logic [MOD_W-1:0] mod_i,
  output logic [INT_W-1:0] int_o,
  output logic [MOD_W-1:0] frac_o,
  output logic [MOD_W-1:0] mod_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_o  <= '0;
      frac_o <= '0;
      mod_o  <= MOD_W'(1);
    end else if (load_i) begin
      int_o  <= int_i;
      frac_o <= frac_i;
      mod_o  <= mod_i;
    end
  end
endmodule

// File: rtl/mash_mod_accum.sv
module mash_mod_accum #(
  parameter int MOD_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [MOD_W-1:0] seed_i,
  input  logic [MOD_W-1:0] add_i,
  input  logic [MOD_W-1:0] mod_i,
  output logic [MOD_W-1:0] next_o,
  output logic [MOD_W-1:0] acc_o,
  output logic             carry_o
);
  logic [MOD_W:0] sum_w;
  logic [MOD_W:0] wrap_w;

  always_comb begin
    sum_w   = {1'b0, acc_o} + {1'b0, add_i};
    carry_o = (sum_w >= {1'b0, mod_i});
    wrap_w  = sum_w - {1'b0, mod_i};
    next_o  = carry_o ? wrap_w[MOD_W-1:0] : sum_w[MOD_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_o <= '0;
    else if (load_i) acc_o <= seed_i;
    else             acc_o <= next_o;
  end
endmodule

// File: rtl/mash_cancel.sv
module mash_cancel
  import mash_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [STAGES-1:0] carry_i,
  output corr_t             corr_o
);
  logic c2_d, c3_d, c3_dd;

  always_comb begin
    corr_o = corr_t'({3'b000, carry_i[0]})
           + corr_t'({3'b000, carry_i[1]}) - corr_t'({3'b000, c2_d})
           + corr_t'({3'b000, carry_i[2]}) - corr_t'({2'b00, c3_d, 1'b0})
           + corr_t'({3'b000, c3_dd});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni || load_i) begin
      c2_d  <= 1'b0;
      c3_d  <= 1'b0;
      c3_dd <= 1'b0;
    end else begin
      c2_d  <= carry_i[1];
      c3_d  <= carry_i[2];
      c3_dd <= c3_d;
    end
  end
endmodule

// File: rtl/phase_seeded_mash.sv
module phase_seeded_mash
  import mash_pkg::*;
#(
  parameter int INT_W = 8,
  parameter int MOD_W = 8,
  localparam int DIV_W = INT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [INT_W-1:0] int_i,
  input  logic [MOD_W-1:0] frac_i,
  input  logic [MOD_W-1:0] mod_i,
  input  logic [MOD_W-1:0] phase_i,
  output logic [DIV_W-1:0] div_o
);
  logic [INT_W-1:0] int_q;
  logic [MOD_W-1:0] frac_q, mod_q;
  logic [STAGES-1:0][MOD_W-1:0] next_w, acc_w;
  logic [STAGES-1:0] carry_w;
  corr_t corr_w;
  logic signed [DIV_W:0] div_sum_w;

  mash_chan_regs #(.INT_W(INT_W), .MOD_W(MOD_W)) u_chan (
    .clk_i, .rst_ni, .load_i, .int_i, .frac_i, .mod_i,
    .int_o(int_q), .frac_o(frac_q), .mod_o(mod_q)
  );

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [MOD_W-1:0] add_w, seed_w;
    if (s == 0) begin : g_first
      assign add_w  = frac_q;
      assign seed_w = phase_i;
    end else begin : g_rest
      assign add_w  = next_w[s-1];
      assign seed_w = '0;
    end
    mash_mod_accum #(.MOD_W(MOD_W)) u_acc (
      .clk_i, .rst_ni, .load_i,
      .seed_i(seed_w), .add_i(add_w), .mod_i(mod_q),
      .next_o(next_w[s]), .acc_o(acc_w[s]), .carry_o(carry_w[s])
    );
  end

  mash_cancel u_cancel (
    .clk_i, .rst_ni, .load_i, .carry_i(carry_w), .corr_o(corr_w)
  );

  assign div_sum_w = $signed({2'b00, int_q}) + corr_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_o <= '0;
    else if (load_i) div_o <= {1'b0, int_i};
    else             div_o <= div_sum_w[DIV_W-1:0];
  end
endmodule

// File: rtl/mash_chk.sv
module mash_chk #(
  parameter int INT_W = 8,
  parameter int MOD_W = 8
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   load_i,
  input logic [INT_W-1:0]       int_i,
  input logic [MOD_W-1:0]       frac_i,
  input logic [MOD_W-1:0]       phase_i,
  input logic [INT_W:0]         div_o,
  input logic [INT_W-1:0]       int_q,
  input logic [MOD_W-1:0]       frac_q,
  input logic [MOD_W-1:0]       mod_q,
  input logic [2:0][MOD_W-1:0]  acc_w
);
  logic zero_mode_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     zero_mode_q <= 1'b1;
    else if (load_i) zero_mode_q <= (frac_i == '0) && (phase_i == '0);
  end

  assert_load_int_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> div_o == {1'b0, $past(int_i)});

  assert_seed_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (acc_w[0] == $past(phase_i)) && (acc_w[1] == '0) && (acc_w[2] == '0));

  assert_acc_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_q != '0) |-> (acc_w[0] < mod_q) && (acc_w[1] < mod_q) && (acc_w[2] < mod_q));

  assert_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, div_o} + (INT_W+2)'(3) >= {2'b00, int_q}) &&
    ({1'b0, div_o} <= {2'b00, int_q} + (INT_W+2)'(4)));

  assert_zero_frac_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_mode_q |-> div_o == {1'b0, int_q});

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(int_q) && $stable(frac_q) && $stable(mod_q));
endmodule

bind phase_seeded_mash mash_chk #(.INT_W(INT_W), .MOD_W(MOD_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .int_i(int_i),
  .frac_i(frac_i), .phase_i(phase_i), .div_o(div_o), .int_q(int_q),
  .frac_q(frac_q), .mod_q(mod_q), .acc_w(acc_w)
);

// File: tb/phase_seeded_mash_tb.sv
`timescale 1ns/1ps
module phase_seeded_mash_tb;
  localparam int INT_W = 8;
  localparam int MOD_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic [INT_W-1:0] int_v = '0;
  logic [MOD_W-1:0] frac_v = '0, mod_v = '0, phase_v = '0;
  logic [INT_W:0] div;

  int n_chk = 0, n_fail = 0;
  int m_int, m_frac, m_mod, a1, a2, a3, c2d, c3d, c3dd;
  int seq_a[20];

  always #2.5 clk = ~clk;

  phase_seeded_mash #(.INT_W(INT_W), .MOD_W(MOD_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .int_i(int_v),
    .frac_i(frac_v), .mod_i(mod_v), .phase_i(phase_v), .div_o(div)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model_step();
    int s, c1, c2, c3, corr;
    s = a1 + m_frac; c1 = (s >= m_mod); a1 = c1 ? s - m_mod : s;
    s = a2 + a1;     c2 = (s >= m_mod); a2 = c2 ? s - m_mod : s;
    s = a3 + a2;     c3 = (s >= m_mod); a3 = c3 ? s - m_mod : s;
    corr = c1 + c2 - c2d + c3 - 2 * c3d + c3dd;
    c2d = c2; c3dd = c3d; c3d = c3;
    return m_int + corr;
  endfunction

  task automatic do_load(input int iv, input int fv, input int mv, input int pv);
    @(negedge clk);
    int_v = INT_W'(iv); frac_v = MOD_W'(fv); mod_v = MOD_W'(mv); phase_v = MOD_W'(pv);
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    m_int = iv; m_frac = fv; m_mod = mv;
    a1 = pv; a2 = 0; a3 = 0; c2d = 0; c3d = 0; c3dd = 0;
    chk(int'(div) == iv, "R2", int'(div), iv);
  endtask

  task automatic run(input int ncyc, input bit scramble, input bit record);
    int sum = 0;
    for (int t = 1; t <= ncyc; t++) begin
      int exp;
      if (scramble) begin
        int_v = INT_W'(t * 37); frac_v = MOD_W'(t * 11);
        mod_v = MOD_W'(t * 5 + 1); phase_v = MOD_W'(t * 3);
      end
      @(negedge clk);
      exp = model_step();
      if (scramble) chk(int'(div) == exp, "R8", int'(div), exp);
      else          chk(int'(div) == exp, "R4", int'(div), exp);
      chk(int'(div) >= m_int - 3 && int'(div) <= m_int + 4, "R4 range", int'(div), m_int);
      if (m_frac == 0 && t == 1 && a1 == 0)
        chk(int'(div) == m_int, "R6", int'(div), m_int);
      if (record && t <= 20) seq_a[t-1] = int'(div);
      sum += int'(div) - m_int;
      if (!scramble && (t % m_mod) == 0) begin
        int dev;
        dev = sum - m_frac * (t / m_mod);
        chk(dev >= -1 && dev <= 2, "R7", dev, 0);
      end
    end
  endtask

  initial begin
    int moduli[5] = '{2, 3, 5, 7, 13};
    repeat (3) @(negedge clk);
    chk(div == '0, "R1", int'(div), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(div == '0, "R1 idle", int'(div), 0);

    foreach (moduli[i]) begin
      for (int f = 0; f < moduli[i]; f++) begin
        for (int p = 0; p < moduli[i]; p++) begin
          do_load(20 + f, f, moduli[i], p);
          run(2 * moduli[i] + 3, 1'b0, 1'b0);
        end
      end
    end

    // FRAC = 0, PHASE = 0: output pinned to INT (R6)
    do_load(100, 0, 9, 0);
    for (int t = 0; t < 30; t++) begin
      @(negedge clk);
      chk(int'(div) == 100, "R6", int'(div), 100);
    end

    // wide modulus, repeatable seeded sequence (R5, R7)
    do_load(144, 40, 65, 26);
    run(4 * 65, 1'b0, 1'b1);
    do_load(7, 3, 11, 5);
    run(10, 1'b0, 1'b0);
    do_load(144, 40, 65, 26);
    for (int t = 0; t < 20; t++) begin
      int exp;
      @(negedge clk);
      exp = model_step();
      chk(int'(div) == seq_a[t], "R5", int'(div), seq_a[t]);
      chk(int'(div) == exp, "R3", int'(div), exp);
    end

    // inputs moving without load are ignored (R8)
    do_load(200, 77, 250, 249);
    run(300, 1'b1, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule